// File: doc/BRIEF.md
# Interrupt Source Control Unit

This block conditions and tracks up to 32 interrupt request sources in front of a processor core. Each source has its own two-bit trigger mode. A source is either level-sensitive or edge-triggered. Sources at or above a configurable index count as external: they pass through a two-flop synchronizer and may also select inverted polarity. Internal sources ignore the polarity bit. An edge-triggered source records the selected edge in a memorization latch, and software can force that latch set or clear. The block drives two active-low request outputs to the core. One is a normal request covering sources 1 and up. The other is a fast request for source 0.

Software reaches the block over a simple single-cycle register bus. Enabling and disabling sources uses separate command words. The resulting mask, the live pending state, the current interrupt number and an image of both request lines can be read back. Reading the normal vector selects the lowest-numbered pending and enabled source from 1 upward, returns its number, and clears that source's edge latch, unless its fast-forcing input is high. Reading the fast vector clears the latch of source 0. Read data appears one cycle after the read strobe.

Register map: 0 mode write (wrData[12:8] source index, wrData[1:0] mode), 1 enable command, 2 disable command, 3 latch set command, 4 latch clear command, 5 mask, 6 pending, 7 normal vector, 8 fast vector, 9 current number, 10 core status. Mode encoding: bit 0 = 1 edge / 0 level, bit 1 = 1 inverted (low level or falling edge; external only).

Top module: `intSrcTop`

## Requirements
- R1: After reset the mask is 0, all modes are level/high, all edge latches are clear, irqN and fiqN are 1, and reading mask (address 5) and pending (address 6) returns 0 while all inputs are low.
- R2: A write to address 1 sets every mask bit whose wrData bit is 1; a write to address 2 clears every mask bit whose wrData bit is 1; zero bits leave the mask unchanged; address 5 returns the mask.
- R3: Pending (address 6) shows every source's live state whether or not it is masked; a masked pending source leaves irqN high.
- R4: In level mode (bit 0 = 0) a source is pending while its input is at the active level; an external source with mode 2'b10 is active low, while an internal source with mode 2'b10 stays active high.
- R5: In edge mode (bit 0 = 1) the latch sets on the selected edge (2'b01 rising; 2'b11 falling for external sources) and stays set after the input returns; the opposite edge does not set it.
- R6: A write of 1 bits to address 3 sets, and to address 4 clears, the edge latch only of sources in edge mode; for level-mode sources these writes have no effect.
- R7: A read of address 7 returns the lowest-numbered pending and enabled source among 1 and up (0 if none), stores it as the current number (address 9), and clears the edge latch of that source and of no other.
- R8: The clear of R7 is suppressed for a source whose fastForce input is 1.
- R9: A read of address 8 returns 0 and clears the edge latch of source 0; a read of address 7 never clears source 0.
- R10: irqN is 0 exactly while some source 1 and up is pending and enabled, and fiqN is 0 exactly while source 0 is pending and enabled; both are registered; a pending but disabled source is neither selected nor blocks the selection of others.
- R11: Address 10 returns irqN in bit 0 and fiqN in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | NUM_SRC | Raw interrupt source inputs |
| fastForce | input | NUM_SRC | Per-source flag suppressing the vector-read clear |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| irqN | output | 1 | Active-low normal interrupt request |
| fiqN | output | 1 | Active-low fast interrupt request |

## Verification
An internal input change reaches pending at once and the registered request lines one clock later. An external input goes through two synchronizer flops first, so its level status is due two clocks after the change, an edge latch three clocks after it, and the request line four clocks after it. Command writes take effect at the write edge, and read data is registered on the read edge. The bench therefore reads results one falling edge after the read strobe's clock. It waits five clock cycles after every input change before it checks pending or the request lines, which covers the longest path.

// File: rtl/intSrcPkg.sv
package intSrcPkg;
  localparam int IDX_W  = 5;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_MODE = 4'd0;
  localparam logic [ADDR_W-1:0] A_EN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_DIS  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SET  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MASK = 4'd5;
  localparam logic [ADDR_W-1:0] A_PEND = 4'd6;
  localparam logic [ADDR_W-1:0] A_IVEC = 4'd7;
  localparam logic [ADDR_W-1:0] A_FVEC = 4'd8;
  localparam logic [ADDR_W-1:0] A_CUR  = 4'd9;
  localparam logic [ADDR_W-1:0] A_CORE = 4'd10;

  typedef struct packed {
    logic              modeWr;
    logic [IDX_W-1:0]  modeIdx;
    logic [1:0]        modeVal;
    logic [DATA_W-1:0] cmdBits;
    logic              enCmd;
    logic              disCmd;
    logic              setCmd;
    logic              clrCmd;
    logic              vecRd;
    logic              fastRd;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
  } strobeT;
endpackage

// File: rtl/intSrcCtrl.sv
module intSrcCtrl
  import intSrcPkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output strobeT            stb
);
  always_comb begin
    stb         = '0;
    stb.cmdBits = wrData;
    stb.modeIdx = wrData[8 +: IDX_W];
    stb.modeVal = wrData[1:0];
    stb.rdAddr  = addr;
    stb.rdEn    = rdEn;
    if (wrEn) begin
      stb.modeWr = (addr == A_MODE);
      stb.enCmd  = (addr == A_EN);
      stb.disCmd = (addr == A_DIS);
      stb.setCmd = (addr == A_SET);
      stb.clrCmd = (addr == A_CLR);
    end
    if (rdEn) begin
      stb.vecRd  = (addr == A_IVEC);
      stb.fastRd = (addr == A_FVEC);
    end
  end
endmodule

// File: rtl/intSrcDp.sv
module intSrcDp
  import intSrcPkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int EXT_FIRST = 28
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] fastForce,
  input  strobeT             stb,
  output logic               irqN,
  output logic               fiqN,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] edgeVec
);
  localparam int CUR_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] lvl, invEff, modeInv, prevLvl, latchR;
  logic [NUM_SRC-1:0] active, prevAct, edgeHit, setMask, clrMask, vecClr, cmdSrc;
  logic [CUR_W-1:0]   pickNum, curNum;
  logic               pickValid;

  assign cmdSrc = stb.cmdBits[NUM_SRC-1:0];

  genvar i;
  for (i = 0; i < NUM_SRC; i++) begin : g_src
    if (i >= EXT_FIRST) begin : g_ext
      logic s1, s2;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          s1 <= 1'b0;
          s2 <= 1'b0;
        end else begin
          s1 <= srcIn[i];
          s2 <= s1;
        end
      end
      assign lvl[i]    = s2;
      assign invEff[i] = modeInv[i];
    end else begin : g_int
      assign lvl[i]    = srcIn[i];
      assign invEff[i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        edgeVec[i] <= 1'b0;
        modeInv[i] <= 1'b0;
      end else if (stb.modeWr && stb.modeIdx == IDX_W'(i)) begin
        edgeVec[i] <= stb.modeVal[0];
        modeInv[i] <= stb.modeVal[1];
      end
    end
  end

  assign active  = lvl ^ invEff;
  assign prevAct = prevLvl ^ invEff;
  assign edgeHit = active & ~prevAct & edgeVec;
  assign pendVec = (edgeVec & latchR) | (~edgeVec & active);

  always_comb begin
    pickNum   = '0;
    pickValid = 1'b0;
    for (int k = NUM_SRC - 1; k >= 1; k--) begin
      if (pendVec[k] && maskVec[k]) begin
        pickNum   = CUR_W'(k);
        pickValid = 1'b1;
      end
    end
  end

  always_comb begin
    vecClr = '0;
    if (stb.vecRd && pickValid && !fastForce[pickNum]) vecClr[pickNum] = 1'b1;
    setMask = edgeHit | (stb.setCmd ? (cmdSrc & edgeVec) : '0);
    clrMask = vecClr | (stb.clrCmd ? (cmdSrc & edgeVec) : '0);
    if (stb.fastRd) clrMask[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl <= '0;
      latchR  <= '0;
      maskVec <= '0;
      curNum  <= '0;
      irqN    <= 1'b1;
      fiqN    <= 1'b1;
    end else begin
      prevLvl <= lvl;
      latchR  <= (latchR & ~clrMask) | setMask;
      if (stb.enCmd)  maskVec <= maskVec | cmdSrc;
      if (stb.disCmd) maskVec <= maskVec & ~cmdSrc;
      if (stb.vecRd)  curNum  <= pickNum;
      irqN <= ~|(pendVec[NUM_SRC-1:1] & maskVec[NUM_SRC-1:1]);
      fiqN <= ~(pendVec[0] & maskVec[0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdEn) begin
      rdData <= '0;
      case (stb.rdAddr)
        A_MASK: rdData[NUM_SRC-1:0] <= maskVec;
        A_PEND: rdData[NUM_SRC-1:0] <= pendVec;
        A_IVEC: rdData[CUR_W-1:0]   <= pickNum;
        A_CUR:  rdData[CUR_W-1:0]   <= curNum;
        A_CORE: rdData[1:0]         <= {fiqN, irqN};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/intSrcTop.sv
module intSrcTop
  import intSrcPkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int EXT_FIRST = 28
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] fastForce,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [3:0]         addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               irqN,
  output logic               fiqN
);
  strobeT             stb;
  logic [NUM_SRC-1:0] pendVec, maskVec, edgeVec;

  intSrcCtrl u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData), .stb(stb)
  );

  intSrcDp #(.NUM_SRC(NUM_SRC), .EXT_FIRST(EXT_FIRST)) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .fastForce(fastForce), .stb(stb),
    .irqN(irqN), .fiqN(fiqN), .rdData(rdData),
    .pendVec(pendVec), .maskVec(maskVec), .edgeVec(edgeVec)
  );
endmodule

// File: rtl/intSrcChk.sv
module intSrcChk
  import intSrcPkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               rdEn,
  input logic [3:0]         addr,
  input logic [NUM_SRC-1:0] wrBits,
  input logic [1:0]         coreRd,
  input logic               irqN,
  input logic               fiqN,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC-1:0] maskVec,
  input logic [NUM_SRC-1:0] edgeVec
);
  // R2: enable command sets the selected mask bits
  a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_EN) |=> ((maskVec & $past(wrBits)) == $past(wrBits)));

  // R2: disable command clears the selected mask bits
  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_DIS) |=> ((maskVec & $past(wrBits)) == '0));

  // R10: fast request follows source 0 pending and enabled, one clock later
  a_r10_fast_request: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fiqN == !$past(pendVec[0] & maskVec[0])));

  // R10: normal request follows sources 1 and up, one clock later
  a_r10_normal_request: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqN == !$past(|(pendVec[NUM_SRC-1:1] & maskVec[NUM_SRC-1:1]))));

  // R9: a normal vector read keeps an edge-latched source 0
  a_r9_normal_keeps_src0: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == A_IVEC && edgeVec[0] && pendVec[0]) |=> pendVec[0]);

  // R11: core status returns the request lines as they stood at the read
  a_r11_core_image: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == A_CORE) |=> (coreRd == {$past(fiqN), $past(irqN)}));
endmodule

bind intSrcTop intSrcChk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrBits(wrData[NUM_SRC-1:0]), .coreRd(rdData[1:0]), .irqN(irqN), .fiqN(fiqN),
  .pendVec(pendVec), .maskVec(maskVec), .edgeVec(edgeVec)
);

// File: tb/intSrcTop_tb.sv
module intSrcTop_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [31:0] fastForce = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqN, fiqN;
  int          testCnt = 0;
  int          failCnt = 0;

  always #2.5 clk = ~clk;

  intSrcTop u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .fastForce(fastForce),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqN(irqN), .fiqN(fiqN)
  );

  // {isWrite, address, write data, expected read data}
  localparam logic [68:0] TBL [10] = '{
    {1'b1, 4'd1, 32'h0000_00F0, 32'h0},
    {1'b0, 4'd5, 32'h0,         32'h0000_00F0},
    {1'b1, 4'd1, 32'h8000_0F00, 32'h0},
    {1'b0, 4'd5, 32'h0,         32'h8000_0FF0},
    {1'b1, 4'd2, 32'h0000_0030, 32'h0},
    {1'b0, 4'd5, 32'h0,         32'h8000_0FC0},
    {1'b1, 4'd1, 32'h0,         32'h0},
    {1'b0, 4'd5, 32'h0,         32'h8000_0FC0},
    {1'b1, 4'd2, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'd5, 32'h0,         32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic setMode(input int idx, input logic [1:0] m);
    busWr(4'd0, {19'b0, 5'(idx), 6'b0, m});
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irqN", {31'b0, irqN}, 32'h1);
    check("R1 fiqN", {31'b0, fiqN}, 32'h1);
    busRd(4'd5, d); check("R1 mask", d, 32'h0);
    busRd(4'd6, d); check("R1 pending", d, 32'h0);

    // R2 table walk of enable/disable commands
    foreach (TBL[n]) begin
      if (TBL[n][68]) busWr(TBL[n][67:64], TBL[n][63:32]);
      else begin
        busRd(TBL[n][67:64], d);
        check($sformatf("R2 step %0d", n), d, TBL[n][31:0]);
      end
    end

    // R3 masked level source visible in pending, request stays high
    srcIn[5] = 1'b1; settle();
    busRd(4'd6, d); check("R3 pending masked", d, 32'h0000_0020);
    check("R3 irqN masked", {31'b0, irqN}, 32'h1);
    busWr(4'd1, 32'h0000_0020); settle();
    check("R10 irqN enabled", {31'b0, irqN}, 32'h0);
    busRd(4'd10, d); check("R11 core status", d, 32'h2);

    // R4 polarity: external low level active, internal ignores inversion
    setMode(30, 2'b10); setMode(6, 2'b10); settle();
    busRd(4'd6, d); check("R4 ext low level input 0", d & 32'h4000_0040, 32'h4000_0000);
    srcIn[30] = 1'b1; settle();
    busRd(4'd6, d); check("R4 ext low level input 1", d & 32'h4000_0000, 32'h0);

    // R5 edge latches
    setMode(29, 2'b11); setMode(7, 2'b01);
    srcIn[29] = 1'b1; settle();
    busRd(4'd6, d); check("R5 falling ignores rise", d & 32'h2000_0000, 32'h0);
    srcIn[29] = 1'b0; settle();
    busRd(4'd6, d); check("R5 falling latched", d & 32'h2000_0000, 32'h2000_0000);
    srcIn[7] = 1'b1; settle(); srcIn[7] = 1'b0; settle();
    busRd(4'd6, d); check("R5 rising pulse held", d & 32'h2000_0080, 32'h2000_0080);

    // R6 software set/clear
    busWr(4'd4, 32'h0000_0080);
    busRd(4'd6, d); check("R6 clear edge", d & 32'h80, 32'h0);
    busWr(4'd3, 32'h0000_0080);
    busRd(4'd6, d); check("R6 set edge", d & 32'h80, 32'h80);
    busWr(4'd4, 32'h0000_0020); busWr(4'd3, 32'h0000_0100);
    busRd(4'd6, d); check("R6 level unaffected", d & 32'h120, 32'h20);

    // R7 vector reads, R10 masked source 5 not selected
    busWr(4'd2, 32'hFFFF_FFFF); busWr(4'd1, 32'h2000_0080);
    busRd(4'd7, d); check("R7 first vector", d, 32'd7);
    busRd(4'd6, d); check("R7 only current cleared", d & 32'h2000_00A0, 32'h2000_0020);
    busRd(4'd9, d); check("R7 current number", d, 32'd7);
    busRd(4'd7, d); check("R10 masked lower skipped", d, 32'd29);
    busRd(4'd7, d); check("R7 none pending", d, 32'd0);
    busRd(4'd9, d); check("R7 current none", d, 32'd0);

    // R8 fast-forced source keeps its latch
    fastForce[7] = 1'b1;
    busWr(4'd3, 32'h0000_0080);
    busRd(4'd7, d); check("R8 vector", d, 32'd7);
    busRd(4'd6, d); check("R8 latch kept", d & 32'h80, 32'h80);

    // R9 source 0 cleared only by fast vector read
    setMode(0, 2'b01);
    busWr(4'd3, 32'h0000_0001); busWr(4'd1, 32'h0000_0001); settle();
    check("R10 fiqN low", {31'b0, fiqN}, 32'h0);
    busRd(4'd7, d); check("R9 normal read vector", d, 32'd7);
    busRd(4'd6, d); check("R9 src0 kept", d & 32'h1, 32'h1);
    busRd(4'd8, d); check("R9 fast read data", d, 32'h0);
    settle();
    busRd(4'd6, d); check("R9 src0 cleared", d & 32'h1, 32'h0);
    check("R9 fiqN released", {31'b0, fiqN}, 32'h1);
    check("R10 irqN still low", {31'b0, irqN}, 32'h0);

    finishRun();
  end
endmodule